// File: doc/BRIEF.md
# Payload-Free Head/Tail Network Interface

This block sits between a cache and its router in a mesh network. It holds no payload storage. It keeps only one head/tail flit pair for outgoing packets and one head for incoming packets. Data flits move directly between the cache and the router, and this interface only sequences the two of them.

An outgoing packet starts when the cache asks to evict a line. The interface builds a head flit from the line address, the flit count and the destination. It offers the head to the router. Once the router takes it, the interface tells the cache to stream. When the router reports that every data flit has arrived, the interface offers the tail.

For an incoming packet, the router presents a head flit addressed to this node. The interface decodes the head, then points the cache at the start address and flit count. When the tail flit turns up, the interface ends the receive with a one-cycle done pulse.

The two directions run as separate state machines.

- The send machine has four states:
  - `SND_IDLE`: waits for an eviction request, then goes to `SND_HEAD`.
  - `SND_HEAD`: offers the head. When the router accepts it, the machine goes to `SND_STREAM`.
  - `SND_STREAM`: the cache streams data. On the router's tail request, the machine goes to `SND_TAIL`.
  - `SND_TAIL`: offers the tail. When the router accepts it, the machine goes back to `SND_IDLE`.
- The receive machine has two states:
  - `RCV_IDLE`: on a head flit for this node, it goes to `RCV_ACTIVE`.
  - `RCV_ACTIVE`: on a tail flit, it goes back to `RCV_IDLE`.

Top module: `ht_netif`

## Requirements
- R1: While reset is low and after its release, the outputs are as follows: tx_valid, ev_stream, rcv_en and rcv_done are 0, and tx_flit, rcv_addr, rcv_len, rcv_src_x and rcv_src_y are 0.
- R2: The flit layout is as follows:
  - bits [37:36] carry the type: 01 head, 10 data, 11 tail.
  - bits [35:34] and [33:32] carry the source x and y.
  - bits [31:30] and [29:28] carry the destination x and y.
  - bits [27:24] carry the flit count.
  - bits [23:0] carry the start address.

  An ev_req seen in `SND_IDLE` makes tx_valid 1 on the next cycle. At that point tx_flit is a head flit with source my_x/my_y and with destination, count and address taken from the ev_* inputs in that cycle.
- R3: While tx_valid is 1 and tx_ready is 0, tx_valid stays 1 and tx_flit does not change, even if the ev_* inputs change.
- R4: ev_stream rises only on the cycle after the head is accepted (tx_valid and tx_ready both 1 in `SND_HEAD`). It stays 1 until a tail_req is seen, and tx_valid is 0 while ev_stream is 1.
- R5: A tail_req seen in `SND_STREAM` makes tx_valid 1 on the next cycle. tx_flit then carries the tail type, the same source and destination, and zero count and address. A tail_req in any other state is ignored.
- R6: When the tail is accepted, tx_valid and tx_flit return to 0 on the next cycle. An ev_req arriving while a packet is in progress is ignored.
- R7: In `RCV_IDLE`, a flit with rx_valid 1, type head and destination equal to my_x/my_y makes rcv_en 1 on the next cycle. rcv_addr, rcv_len, rcv_src_x and rcv_src_y then show that head's fields.
- R8: In `RCV_IDLE`, data flits, tail flits and heads for another node are ignored. In `RCV_ACTIVE`, data and head flits are ignored and the captured fields do not change.
- R9: A tail flit in `RCV_ACTIVE` makes rcv_en 0 on the next cycle, and rcv_done is 1 for exactly that one cycle. rcv_addr, rcv_len, rcv_src_x and rcv_src_y return to 0 at the same time.
- R10: Send and receive progress independently. A packet can be sent while a receive is active, and each behaves as it would alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| my_x | input | 2 | This node's x coordinate |
| my_y | input | 2 | This node's y coordinate |
| ev_req | input | 1 | Eviction request from the cache |
| ev_addr | input | 24 | Start address of the evicted line |
| ev_len | input | 4 | Number of data flits to send |
| ev_dst_x | input | 2 | Destination x |
| ev_dst_y | input | 2 | Destination y |
| ev_stream | output | 1 | Cache may stream data flits to the router |
| tx_valid | output | 1 | Head or tail flit offered to the router |
| tx_flit | output | 38 | Offered flit |
| tx_ready | input | 1 | Router accepts the offered flit |
| tail_req | input | 1 | Router holds all data flits and wants the tail |
| rx_valid | input | 1 | Router presents a flit to the interface |
| rx_flit | input | 38 | Presented flit |
| rcv_en | output | 1 | Cache should take data flits from the router |
| rcv_addr | output | 24 | Start address of the incoming data |
| rcv_len | output | 4 | Incoming data flit count |
| rcv_src_x | output | 2 | Sender x |
| rcv_src_y | output | 2 | Sender y |
| rcv_done | output | 1 | One-cycle pulse: receive finished |

## Verification
A send machine stuck in the wrong state shows up at the ports within one cycle. It either offers a flit while ev_stream is high, or leaves ev_stream high after a tail request. A lost or stale head register shows up as a wrong tx_flit on the first cycle the head is offered, or as a change while it waits for tx_ready. On the receive side, a wrong state shows as rcv_en or rcv_done differing from the reference on the cycle after a head or tail. The bench keeps a behavioural model of both machines and compares every output on every clock, so any such error is reported in the cycle it first appears.

// File: rtl/ht_pkg.sv
package ht_pkg;
    localparam int COORD_W = 2;
    localparam int LEN_W   = 4;
    localparam int ADDR_W  = 24;
    localparam int TAG_W   = 2;
    localparam int FLIT_W  = TAG_W + 4 * COORD_W + LEN_W + ADDR_W;

    typedef enum logic [TAG_W-1:0] {
        FT_NONE = 2'b00,
        FT_HEAD = 2'b01,
        FT_DATA = 2'b10,
        FT_TAIL = 2'b11
    } ftag_e;

    typedef struct packed {
        ftag_e               tag;
        logic [COORD_W-1:0]  sx;
        logic [COORD_W-1:0]  sy;
        logic [COORD_W-1:0]  dx;
        logic [COORD_W-1:0]  dy;
        logic [LEN_W-1:0]    len;
        logic [ADDR_W-1:0]   addr;
    } flit_t;

    typedef enum logic [1:0] {
        SND_IDLE,
        SND_HEAD,
        SND_STREAM,
        SND_TAIL
    } snd_st_e;

    typedef enum logic {
        RCV_IDLE,
        RCV_ACTIVE
    } rcv_st_e;
endpackage

// File: rtl/ht_send_fsm.sv
module ht_send_fsm
    import ht_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [COORD_W-1:0] my_x,
    input  logic [COORD_W-1:0] my_y,
    input  logic               ev_req,
    input  logic [ADDR_W-1:0]  ev_addr,
    input  logic [LEN_W-1:0]   ev_len,
    input  logic [COORD_W-1:0] ev_dst_x,
    input  logic [COORD_W-1:0] ev_dst_y,
    input  logic               tx_ready,
    input  logic               tail_req,
    output logic               tx_valid,
    output flit_t              tx_flit,
    output logic               ev_stream
);
    snd_st_e state_q, state_d;
    flit_t   head_q, tail_q;

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SND_IDLE:   if (ev_req)   state_d = SND_HEAD;
            SND_HEAD:   if (tx_ready) state_d = SND_STREAM;
            SND_STREAM: if (tail_req) state_d = SND_TAIL;
            SND_TAIL:   if (tx_ready) state_d = SND_IDLE;
            default:                  state_d = SND_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SND_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // head/tail pair: captured once per packet, in idle only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
        end else if (state_q == SND_IDLE && ev_req) begin
            head_q <= '{tag: FT_HEAD, sx: my_x, sy: my_y, dx: ev_dst_x,
                        dy: ev_dst_y, len: ev_len, addr: ev_addr};
            tail_q <= '{tag: FT_TAIL, sx: my_x, sy: my_y, dx: ev_dst_x,
                        dy: ev_dst_y, len: '0, addr: '0};
        end
    end

    // outputs
    always_comb begin
        tx_valid  = 1'b0;
        tx_flit   = '0;
        ev_stream = 1'b0;
        unique case (state_q)
            SND_IDLE:   ;
            SND_HEAD:   begin tx_valid = 1'b1; tx_flit = head_q; end
            SND_STREAM: ev_stream = 1'b1;
            SND_TAIL:   begin tx_valid = 1'b1; tx_flit = tail_q; end
            default:    ;
        endcase
    end
endmodule

// File: rtl/ht_recv_fsm.sv
module ht_recv_fsm
    import ht_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [COORD_W-1:0] my_x,
    input  logic [COORD_W-1:0] my_y,
    input  logic               rx_valid,
    input  flit_t              rx_flit,
    output logic               rcv_en,
    output logic [ADDR_W-1:0]  rcv_addr,
    output logic [LEN_W-1:0]   rcv_len,
    output logic [COORD_W-1:0] rcv_src_x,
    output logic [COORD_W-1:0] rcv_src_y,
    output logic               rcv_done
);
    rcv_st_e state_q, state_d;
    flit_t   head_q;
    logic    done_q;
    logic    head_hit, tail_hit;

    assign head_hit = rx_valid && (rx_flit.tag == FT_HEAD)
                      && (rx_flit.dx == my_x) && (rx_flit.dy == my_y);
    assign tail_hit = rx_valid && (rx_flit.tag == FT_TAIL);

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RCV_IDLE:   if (head_hit) state_d = RCV_ACTIVE;
            RCV_ACTIVE: if (tail_hit) state_d = RCV_IDLE;
            default:                  state_d = RCV_IDLE;
        endcase
    end

    // state register, captured head and done pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RCV_IDLE;
            head_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == RCV_ACTIVE) && tail_hit;
            if (state_q == RCV_IDLE && head_hit) begin
                head_q <= rx_flit;
            end
        end
    end

    // outputs
    always_comb begin
        rcv_en    = 1'b0;
        rcv_addr  = '0;
        rcv_len   = '0;
        rcv_src_x = '0;
        rcv_src_y = '0;
        rcv_done  = done_q;
        unique case (state_q)
            RCV_IDLE:   ;
            RCV_ACTIVE: begin
                rcv_en    = 1'b1;
                rcv_addr  = head_q.addr;
                rcv_len   = head_q.len;
                rcv_src_x = head_q.sx;
                rcv_src_y = head_q.sy;
            end
            default:    ;
        endcase
    end
endmodule

// File: rtl/ht_netif.sv
module ht_netif
    import ht_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [COORD_W-1:0] my_x,
    input  logic [COORD_W-1:0] my_y,
    input  logic               ev_req,
    input  logic [ADDR_W-1:0]  ev_addr,
    input  logic [LEN_W-1:0]   ev_len,
    input  logic [COORD_W-1:0] ev_dst_x,
    input  logic [COORD_W-1:0] ev_dst_y,
    output logic               ev_stream,
    output logic               tx_valid,
    output logic [FLIT_W-1:0]  tx_flit,
    input  logic               tx_ready,
    input  logic               tail_req,
    input  logic               rx_valid,
    input  logic [FLIT_W-1:0]  rx_flit,
    output logic               rcv_en,
    output logic [ADDR_W-1:0]  rcv_addr,
    output logic [LEN_W-1:0]   rcv_len,
    output logic [COORD_W-1:0] rcv_src_x,
    output logic [COORD_W-1:0] rcv_src_y,
    output logic               rcv_done
);
    flit_t tx_flit_s;
    flit_t rx_flit_s;

    assign tx_flit   = tx_flit_s;
    assign rx_flit_s = rx_flit;

    ht_send_fsm u_send (
        .clk       (clk),
        .rst_n     (rst_n),
        .my_x      (my_x),
        .my_y      (my_y),
        .ev_req    (ev_req),
        .ev_addr   (ev_addr),
        .ev_len    (ev_len),
        .ev_dst_x  (ev_dst_x),
        .ev_dst_y  (ev_dst_y),
        .tx_ready  (tx_ready),
        .tail_req  (tail_req),
        .tx_valid  (tx_valid),
        .tx_flit   (tx_flit_s),
        .ev_stream (ev_stream)
    );

    ht_recv_fsm u_recv (
        .clk       (clk),
        .rst_n     (rst_n),
        .my_x      (my_x),
        .my_y      (my_y),
        .rx_valid  (rx_valid),
        .rx_flit   (rx_flit_s),
        .rcv_en    (rcv_en),
        .rcv_addr  (rcv_addr),
        .rcv_len   (rcv_len),
        .rcv_src_x (rcv_src_x),
        .rcv_src_y (rcv_src_y),
        .rcv_done  (rcv_done)
    );
endmodule

// File: rtl/ht_netif_chk.sv
module ht_netif_chk
    import ht_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              ev_stream,
    input logic              tx_valid,
    input logic [FLIT_W-1:0] tx_flit,
    input logic              tx_ready,
    input logic              rcv_en,
    input logic              rcv_done
);
    // R3
    hold_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_flit)));

    // R4
    stream_after_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ev_stream) |-> $past(tx_valid && tx_ready));

    // R4
    no_offer_in_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stream |-> !tx_valid);

    // R2
    offer_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (tx_flit[FLIT_W-1 -: TAG_W] == FT_HEAD
                      || tx_flit[FLIT_W-1 -: TAG_W] == FT_TAIL));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rcv_done |=> !rcv_done);

    // R9
    done_after_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rcv_done |-> (!rcv_en && $past(rcv_en)));
endmodule

bind ht_netif ht_netif_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_stream (ev_stream),
    .tx_valid  (tx_valid),
    .tx_flit   (tx_flit),
    .tx_ready  (tx_ready),
    .rcv_en    (rcv_en),
    .rcv_done  (rcv_done)
);

// File: tb/ht_netif_tb.sv
module ht_netif_tb;
    import ht_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;
    localparam int FW         = FLIT_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [COORD_W-1:0] my_x = 2'd1, my_y = 2'd2;
    logic              ev_req = 1'b0;
    logic [ADDR_W-1:0] ev_addr = '0;
    logic [LEN_W-1:0]  ev_len = '0;
    logic [COORD_W-1:0] ev_dst_x = '0, ev_dst_y = '0;
    logic              ev_stream, tx_valid, tx_ready = 1'b0, tail_req = 1'b0;
    logic [FW-1:0]     tx_flit;
    logic              rx_valid = 1'b0;
    logic [FW-1:0]     rx_flit = '0;
    logic              rcv_en, rcv_done;
    logic [ADDR_W-1:0] rcv_addr;
    logic [LEN_W-1:0]  rcv_len;
    logic [COORD_W-1:0] rcv_src_x, rcv_src_y;

    ht_netif u_dut (
        .clk(clk), .rst_n(rst_n), .my_x(my_x), .my_y(my_y),
        .ev_req(ev_req), .ev_addr(ev_addr), .ev_len(ev_len),
        .ev_dst_x(ev_dst_x), .ev_dst_y(ev_dst_y), .ev_stream(ev_stream),
        .tx_valid(tx_valid), .tx_flit(tx_flit), .tx_ready(tx_ready),
        .tail_req(tail_req), .rx_valid(rx_valid), .rx_flit(rx_flit),
        .rcv_en(rcv_en), .rcv_addr(rcv_addr), .rcv_len(rcv_len),
        .rcv_src_x(rcv_src_x), .rcv_src_y(rcv_src_y), .rcv_done(rcv_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit finished = 0;

    // behavioural reference model
    int          m_snd = 0;   // 0 idle, 1 head offered, 2 streaming, 3 tail offered
    int          m_rcv = 0;   // 0 idle, 1 receiving
    logic [FW-1:0] m_head = '0, m_tail = '0;
    longint      m_addr = 0;
    int          m_len = 0, m_sx = 0, m_sy = 0;
    bit          m_done = 0;

    function automatic logic [FW-1:0] mk(int tag, int sx, int sy, int dx, int dy,
                                        int len, longint addr);
        return {TAG_W'(tag), COORD_W'(sx), COORD_W'(sy), COORD_W'(dx),
                COORD_W'(dy), LEN_W'(len), ADDR_W'(addr)};
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_snd = 0; m_rcv = 0; m_head = '0; m_tail = '0;
            m_addr = 0; m_len = 0; m_sx = 0; m_sy = 0; m_done = 0;
        end else begin
            case (m_snd)
                0: if (ev_req) begin
                       m_head = mk(1, my_x, my_y, ev_dst_x, ev_dst_y, ev_len, ev_addr);
                       m_tail = mk(3, my_x, my_y, ev_dst_x, ev_dst_y, 0, 0);
                       m_snd = 1;
                   end
                1: if (tx_ready) m_snd = 2;
                2: if (tail_req) m_snd = 3;
                default: if (tx_ready) m_snd = 0;
            endcase
            m_done = 0;
            if (m_rcv == 0) begin
                if (rx_valid && rx_flit[FW-1 -: TAG_W] == 2'b01
                    && rx_flit[FW-TAG_W-2*COORD_W-1 -: COORD_W] == my_x
                    && rx_flit[FW-TAG_W-3*COORD_W-1 -: COORD_W] == my_y) begin
                    m_rcv  = 1;
                    m_sx   = int'(rx_flit[FW-TAG_W-1 -: COORD_W]);
                    m_sy   = int'(rx_flit[FW-TAG_W-COORD_W-1 -: COORD_W]);
                    m_len  = int'(rx_flit[ADDR_W +: LEN_W]);
                    m_addr = longint'(rx_flit[ADDR_W-1:0]);
                end
            end else if (rx_valid && rx_flit[FW-1 -: TAG_W] == 2'b11) begin
                m_rcv  = 0;
                m_done = 1;
            end
        end
    end

    task automatic chk(string rq, string nm, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s at cycle %0d: actual %h expected %h", rq, nm, cyc, act, exp);
        end
    endtask

    // compare every output on every falling edge
    always @(negedge clk) begin
        if (cyc > 0 && !finished) begin
            chk("R1/R2/R5/R6", "tx_valid", 64'(tx_valid), 64'(m_snd == 1 || m_snd == 3));
            chk("R2/R3/R5/R6", "tx_flit", 64'(tx_flit),
                (m_snd == 1) ? 64'(m_head) : (m_snd == 3) ? 64'(m_tail) : 64'd0);
            chk("R1/R4/R10", "ev_stream", 64'(ev_stream), 64'(m_snd == 2));
            chk("R1/R7/R8/R9", "rcv_en", 64'(rcv_en), 64'(m_rcv == 1));
            chk("R7/R8", "rcv_addr", 64'(rcv_addr), (m_rcv == 1) ? 64'(m_addr) : 64'd0);
            chk("R7/R8", "rcv_len", 64'(rcv_len), (m_rcv == 1) ? 64'(m_len) : 64'd0);
            chk("R7", "rcv_src", 64'({rcv_src_x, rcv_src_y}),
                (m_rcv == 1) ? 64'((m_sx << COORD_W) | m_sy) : 64'd0);
            chk("R1/R9", "rcv_done", 64'(rcv_done), 64'(m_done));
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic evict(longint addr, int len, int dx, int dy);
        ev_req = 1'b1; ev_addr = ADDR_W'(addr); ev_len = LEN_W'(len);
        ev_dst_x = COORD_W'(dx); ev_dst_y = COORD_W'(dy);
        tick(1);
        ev_req = 1'b0;
    endtask

    task automatic send_rx(int tag, int sx, int sy, int dx, int dy, int len, longint addr);
        rx_valid = 1'b1; rx_flit = mk(tag, sx, sy, dx, dy, len, addr);
        tick(1);
        rx_valid = 1'b0; rx_flit = '0;
    endtask

    task automatic summary();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        fails++;
        $display("FAIL watchdog expired at cycle %0d: actual running expected finished", cyc);
        summary();
    end

    initial begin
        // R1: outputs during and after reset
        tick(3);
        rst_n = 1'b1;
        tick(2);

        // R2, R3: head built, held while router stalls, inputs changed meanwhile
        evict(24'h00A5C0, 5, 3, 0);
        ev_addr = 24'hFFFFFF; ev_len = 4'hF;
        tail_req = 1'b1;                  // R5: ignored outside streaming
        tick(3);
        tail_req = 1'b0;
        tx_ready = 1'b1; tick(1); tx_ready = 1'b0;
        // R4: streaming; R6: new eviction ignored while busy
        evict(24'h111111, 2, 1, 1);
        tick(3);
        tail_req = 1'b1; tick(1); tail_req = 1'b0;
        tick(2);                          // R5: tail held
        tx_ready = 1'b1; tick(1); tx_ready = 1'b0;
        tick(2);                          // R6: back to idle

        // R8: flits ignored while receive idle
        send_rx(2, 0, 0, 1, 2, 3, 24'h000100);
        send_rx(3, 0, 0, 1, 2, 3, 24'h000100);
        send_rx(1, 0, 0, 2, 2, 3, 24'h000100);  // head for another node
        tick(1);
        // R7: head for this node
        send_rx(1, 3, 1, 1, 2, 7, 24'h0BEEF0);
        send_rx(2, 3, 1, 1, 2, 7, 24'h0BEEF0);
        send_rx(1, 0, 3, 1, 2, 9, 24'h123456);  // R8: second head ignored
        tick(2);
        // R9: tail ends it
        send_rx(3, 3, 1, 1, 2, 0, 0);
        tick(3);

        // R10: overlapping send and receive
        evict(24'h3C3C3C, 8, 0, 3);
        send_rx(1, 2, 0, 1, 2, 4, 24'h00F00D);
        tx_ready = 1'b1; tick(1); tx_ready = 1'b0;
        send_rx(2, 2, 0, 1, 2, 4, 24'h00F00D);
        send_rx(3, 2, 0, 1, 2, 0, 0);
        tail_req = 1'b1; tick(1); tail_req = 1'b0;
        evict(24'h777777, 1, 2, 2);              // R6: ignored, tail pending
        tx_ready = 1'b1; tick(1); tx_ready = 1'b0;
        tick(1);

        // R2, R5: back-to-back packets with the router always ready
        tx_ready = 1'b1;
        evict(24'h000001, 1, 1, 3);
        tick(1);
        tail_req = 1'b1; tick(1); tail_req = 1'b0;
        tick(1);
        evict(24'hABCDEF, 15, 2, 1);
        tick(2);
        tail_req = 1'b1; tick(1); tail_req = 1'b0;
        tick(2);
        tx_ready = 1'b0;

        // R1: reset in the middle of a send and a receive
        evict(24'h020202, 3, 3, 3);
        send_rx(1, 1, 1, 1, 2, 2, 24'h000222);
        rst_n = 1'b0; tick(2); rst_n = 1'b1;
        tick(3);
        summary();
    end
endmodule